// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product. It does this over several clock cycles with one adder, not with a combinational array. A one-cycle `start` pulse captures both operands while the unit is idle. The block then runs one shift-and-add step per clock until it has run 32 steps. When it finishes, it drops `busy`, raises `done` for a single cycle, and holds the product on its output until the next accepted start.

Inside, the multiplicand sits in a register twice the operand width. It starts with zeros in its upper half and moves one place toward the most significant end on every step. The multiplier sits in an operand-wide register and moves one place toward the least significant end on every step. On each step, a 64-bit accumulator takes the sum of itself and the multiplicand register, but only when the multiplier's lowest bit is set.

Top module: `seqmul_top`

## Requirements
- R1: A synchronous active-high `rst` held over a rising edge leaves `busy` = 0, `done` = 0 and `product` = 0 after that edge.
- R2: When `start` is high at a rising edge while `busy` is 0, the operands are captured at that edge and `busy` is 1 after it.
- R3: The result on `product` equals the unsigned 64-bit product of the captured `mcand_i` and `mplier_i`, including the operand values 0, 1 and all-ones.
- R4: After an accepted start, `busy` stays 1 for exactly 32 clock cycles. `busy` then goes to 0 and `done` is 1 for exactly one cycle. `done` and `busy` are never 1 together.
- R5: A `start` pulse while `busy` is 1 has no effect: the operands are not recaptured, the run length does not change, and the result is that of the original operands.
- R6: While `busy` is 0 and no start is accepted, `product` keeps its value, including in the cycles after `done` falls.
- R7: On each step, the accumulator grows by the shifted multiplicand only when the multiplier's current lowest bit is 1, and is unchanged otherwise. Alternating-bit multipliers (0xAAAAAAAA, 0x55555555) exercise both cases.
- R8: Asserting `rst` in the middle of a run aborts it: the next cycle shows `busy` = 0, `done` = 0 and `product` = 0, and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; taken only while idle |
| mcand_i | input | 32 | Unsigned multiplicand |
| mplier_i | input | 32 | Unsigned multiplier |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse after the last step |
| product | output | 64 | Unsigned product, held until the next accepted start |

## Verification
The hardest case to reach from the ports is a second start that arrives while a run is in progress, because it must leave the captured operands and the step count untouched. The bench raises `start` with different operands at a chosen middle step of a run. It then checks that the run still takes 32 cycles and that the result matches the first operand pair. A reset in the middle of a run is driven the same way, at a chosen step.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    // Default operand width; the product is twice as wide.
    localparam int DEF_OP_W = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Width of a counter that indexes steps 0 .. w-1.
    function automatic int step_cnt_w(input int w);
        return (w > 2) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int OP_W = DEF_OP_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int             CW   = step_cnt_w(OP_W);
    localparam logic [CW-1:0]  LAST = CW'(OP_W - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign load = start && (state_q == ST_IDLE);
    assign step = (state_q == ST_RUN);
    assign busy = (state_q == ST_RUN);
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R4
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != LAST) |=> busy);

    // R5
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/seqmul_dpath.sv
module seqmul_dpath
    import seqmul_pkg::*;
#(
    parameter int OP_W = DEF_OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [OP_W-1:0]   mcand_i,
    input  logic [OP_W-1:0]   mplier_i,
    output logic [2*OP_W-1:0] product
);
    localparam int PW = 2 * OP_W;

    typedef struct packed {
        logic [PW-1:0]   mcand;   // shifts toward the MSB each step
        logic [OP_W-1:0] mplier;  // shifts toward the LSB each step
        logic [PW-1:0]   acc;     // running sum of partial products
    } dp_regs_t;

    dp_regs_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.mcand  = {{OP_W{1'b0}}, mcand_i};
            d.mplier = mplier_i;
            d.acc    = '0;
        end else if (step) begin
            if (q.mplier[0]) begin
                d.acc = q.acc + q.mcand;
            end
            d.mcand  = q.mcand << 1;
            d.mplier = q.mplier >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign product = q.acc;

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q.acc == '0) && (q.mplier == $past(mplier_i))
                 && (q.mcand[PW-1:OP_W] == '0));

    // R7
    skip_add_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !q.mplier[0]) |=> $stable(q.acc));

    // R7
    mplier_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> ($countones(q.mplier) <= $countones($past(q.mplier))));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(q));

endmodule

// File: rtl/seqmul_top.sv
module seqmul_top
    import seqmul_pkg::*;
#(
    parameter int OP_W = DEF_OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   mcand_i,
    input  logic [OP_W-1:0]   mplier_i,
    output logic              busy,
    output logic              done,
    output logic [2*OP_W-1:0] product
);
    logic load, step;

    seqmul_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    seqmul_dpath #(.OP_W(OP_W)) u_dpath (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .product  (product)
    );

    // R6
    product_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

endmodule

// File: tb/tb_seqmul_top.sv
module tb_seqmul_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int WATCHDOG_CYCLES = 20000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   a = '0;
    logic [W-1:0]   b = '0;
    logic           busy, done;
    logic [2*W-1:0] product;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    seqmul_top #(.OP_W(W)) dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mcand_i  (a),
        .mplier_i (b),
        .busy     (busy),
        .done     (done),
        .product  (product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [2*W-1:0] xe, ye;
        xe = {{W{1'b0}}, x};
        ye = {{W{1'b0}}, y};
        return xe * ye;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one multiplication; if mid > 0, pulse start with junk operands
    // at that step. Checks R2, R4, R3, R5 and R6.
    task automatic run_mul(input logic [W-1:0] x, input logic [W-1:0] y, input int mid,
                           input string tag);
        logic [2*W-1:0] exp;
        exp = ref_mul(x, y);
        @(negedge clk);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, "R2 busy after start", {62'b0, busy, done}, 64'h2);
        for (int c = 1; c <= 31; c++) begin
            @(negedge clk);
            if (c == mid) begin
                start = 1'b1; a = ~x; b = y ^ 32'h0F0F_0F0F;
            end else begin
                start = 1'b0;
            end
            if (c == 31 || c == mid + 1)
                chk(busy === 1'b1 && done === 1'b0, "R4 still busy", {62'b0, busy, done}, 64'h2);
        end
        start = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b1, "R4 done after 32 steps", {62'b0, busy, done}, 64'h1);
        if (mid > 0)
            chk(product === exp, {"R5 start while busy ignored ", tag}, product, exp);
        else
            chk(product === exp, {"R3 product ", tag}, product, exp);
        @(negedge clk);
        chk(done === 1'b0 && product === exp, "R4/R6 done one cycle, product held",
            product, exp);
        a = ~a; b = ~b;
        repeat (2) @(negedge clk);
        chk(product === exp && busy === 1'b0, "R6 product stable while idle", product, exp);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int seed_init;
        seed_init = $urandom(32'd1357);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1 reset state",
            {busy, done, product[61:0]}, 64'h0);

        // Directed corners (R3)
        run_mul(32'h0000_0000, 32'h1234_5678, 0, "zero mcand");
        run_mul(32'hDEAD_BEEF, 32'h0000_0000, 0, "zero mplier");
        run_mul(32'h0000_0001, 32'h89AB_CDEF, 0, "one mcand");
        run_mul(32'h7654_3210, 32'h0000_0001, 0, "one mplier");
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "all ones");
        run_mul(32'hFFFF_FFFF, 32'h8000_0000, 0, "msb mplier");
        // R7 alternating multiplier bits: add and skip steps interleaved
        run_mul(32'h1357_9BDF, 32'hAAAA_AAAA, 0, "R7 alt A");
        run_mul(32'hFFFF_FFFF, 32'h5555_5555, 0, "R7 alt 5");

        // Random pairs (R3)
        for (int i = 0; i < 20; i++) begin
            run_mul($urandom, $urandom, 0, "random");
        end

        // Start while busy (R5) at early, middle and late steps
        run_mul(32'hCAFE_F00D, 32'h0BAD_BEEF, 1, "early");
        run_mul(32'h0001_0001, 32'hFFFF_0000, 15, "middle");
        run_mul($urandom, $urandom, 30, "late");

        // R8 reset during a run
        @(negedge clk);
        a = 32'h1111_2222; b = 32'h3333_4444; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy === 1'b0 && done === 1'b0 && product === '0, "R8 reset aborts run",
            {busy, done, product[61:0]}, 64'h0);
        begin
            bit saw_done;
            saw_done = 1'b0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (done !== 1'b0 || busy !== 1'b0) saw_done = 1'b1;
            end
            chk(!saw_done && product === '0, "R8 no done after abort",
                {63'b0, saw_done}, 64'h0);
        end

        // Normal operation after the abort
        run_mul(32'h0000_FFFF, 32'h0001_0000, 0, "after abort");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule